// File: doc/BRIEF.md
# Scan-Chain Command Decoder with Register Bank

This block sits behind a user-defined data register of a boundary-scan (JTAG) port. An external TAP controller supplies the register-select, capture, shift and update strobes together with TCK and TDI. The block returns TDO. Software on the far side of the scan chain uses framed commands to load a small bank of registers and to read registers back. A frame is either a 38-bit write or a 6-bit read request, and each carries an odd-parity bit.

The bank holds eight 32-bit work words, three further 32-bit data words and a clock-setting word. The clock-setting word is written with twice the wanted multiplier and is driven to an external clock generator. One address is not a register: reading it returns the head of an external result FIFO and pops that FIFO with a one-cycle strobe. When the FIFO is empty, this read returns all ones and nothing is popped. A read request names an address, and the data-register scan that follows shifts the 32-bit value out of TDO, least-significant bit first.

Top module: `jtag_cmd_regbank`

## Requirements
- R1: A write frame holds the data in bits 31:0, the address in bits 35:32, a write flag of 1 in bit 36 and parity in bit 37. A correct write changes the addressed register in the cycle after the update strobe. No register changes in any other cycle.
- R2: A frame is accepted only if its total count of ones, including the parity bit, is odd. A write or read request with even parity has no effect, and the scan after an even-parity read request shifts out zeros.
- R3: A read request holds the address in bits 3:0, a write flag of 0 in bit 4 and parity in bit 5. The capture of the next scan loads the addressed 32-bit value. Bit k of that value is on TDO after the capture edge and k shift edges. Frame bits enter on TDI in order, bit 0 first.
- R4: Addresses 1 to 8 map to work words 0 to 7, addresses 9 to 11 map to data words 0 to 2, and address 13 is the clock-setting word. Writes to addresses 0, 12, 14 and 15 change nothing. Reads of addresses 0, 12 and 15 return zero.
- R5: A read of address 14 returns the FIFO head when the FIFO is not empty, and 0xFFFFFFFF when it is empty.
- R6: The pop strobe is high only during the capture cycle of a scan that follows an address-14 read request. It is high only when the FIFO is not empty, and for a single cycle.
- R7: A frame is ignored if the number of shift cycles between capture and update is neither 6 nor 38. A 38-bit frame with write flag 0 is ignored. A 6-bit frame with write flag 1 is ignored.
- R8: After reset, all work and data words are zero, the clock-setting word holds 190, and TDO is 0.
- R9: Strobes have no effect while the register-select input is low.
- R10: A read request is consumed by one capture. A capture with no pending request shifts out zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Scan clock; all state changes on its rising edge |
| trst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | This data register is selected by the TAP |
| capture | input | 1 | Capture-DR strobe |
| shift | input | 1 | Shift-DR strobe |
| update | input | 1 | Update-DR strobe |
| tdi | input | 1 | Serial data in |
| tdo | output | 1 | Serial data out (shift register bit 0) |
| fifo_empty | input | 1 | Result FIFO has no entry |
| fifo_data | input | 32 | Result FIFO head entry |
| fifo_pop | output | 1 | Pop one FIFO entry (capture cycle only) |
| work_words | output | 256 | Eight work words; word i at bits 32*i+31:32*i |
| aux_words | output | 96 | Three data words, packed the same way |
| clk_setting | output | 32 | Clock-setting word |

## Verification
A written register is due one TCK edge after the update strobe. The pop strobe is combinational and is due in the same cycle as the capture strobe. Bit k of a read value is due on TDO after the capture edge plus k shift edges. The bench drives inputs on the falling edge and advances a behavioural model of queues and arrays on the rising edge. Half a period later, it compares every output with that model, so each result is checked in the cycle in which it is due and not before. Directed checks sample outputs at the same point, after the scan task has issued its last strobe.

// File: rtl/jcr_pkg.sv
package jcr_pkg;
  localparam int WORD_W = 32;
  localparam int ADDR_W = 4;
  localparam int WR_LEN = WORD_W + ADDR_W + 2;
  localparam int RD_LEN = ADDR_W + 2;
  localparam int CNT_W  = $clog2(WR_LEN + 2);

  typedef logic [WORD_W-1:0] word_t;
  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [WR_LEN-1:0] frame_t;
  typedef logic [CNT_W-1:0]  cnt_t;

  typedef struct packed {
    logic  wr;
    logic  rd;
    addr_t addr;
    word_t data;
  } cmd_t;
endpackage

// File: rtl/jcr_rst_sync.sv
module jcr_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic stage_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      stage_q <= 1'b0;
      rst_n   <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      rst_n   <= stage_q;
    end
  end
endmodule

// File: rtl/jcr_shift_path.sv
module jcr_shift_path
  import jcr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   cap_en,
  input  logic   shf_en,
  input  word_t  load_val,
  input  logic   tdi,
  output frame_t sr,
  output cnt_t   cnt,
  output logic   tdo
);
  localparam cnt_t CNT_MAX = cnt_t'(WR_LEN + 1);

  frame_t sr_d;
  cnt_t   cnt_d;
  logic   sr_en;

  // capture reloads and restarts the length count; shift moves toward bit 0
  always_comb begin
    sr_d  = sr;
    cnt_d = cnt;
    if (cap_en) begin
      sr_d  = frame_t'(load_val);
      cnt_d = '0;
    end else if (shf_en) begin
      sr_d = {tdi, sr[WR_LEN-1:1]};
      if (cnt != CNT_MAX) cnt_d = cnt + 1'b1;
    end
  end

  assign sr_en = cap_en | shf_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr  <= '0;
      cnt <= '0;
    end else if (sr_en) begin
      sr  <= sr_d;
      cnt <= cnt_d;
    end
  end

  assign tdo = sr[0];
endmodule

// File: rtl/jcr_frame_decode.sv
module jcr_frame_decode
  import jcr_pkg::*;
(
  input  logic   upd_en,
  input  frame_t sr,
  input  cnt_t   cnt,
  output cmd_t   cmd
);
  logic [RD_LEN-1:0] short_f;
  logic              long_ok;
  logic              short_ok;

  // a short frame sits in the top RD_LEN bits, since TDI enters at the top
  always_comb begin
    short_f  = sr[WR_LEN-1 -: RD_LEN];
    long_ok  = (cnt == cnt_t'(WR_LEN)) && (^sr) && sr[WORD_W+ADDR_W];
    short_ok = (cnt == cnt_t'(RD_LEN)) && (^short_f) && !short_f[ADDR_W];
    cmd.wr   = upd_en && long_ok;
    cmd.rd   = upd_en && short_ok;
    cmd.addr = long_ok ? sr[WORD_W +: ADDR_W] : short_f[ADDR_W-1:0];
    cmd.data = sr[WORD_W-1:0];
  end
endmodule

// File: rtl/jcr_reg_bank.sv
module jcr_reg_bank
  import jcr_pkg::*;
#(
  parameter int    N_WORK    = 8,
  parameter int    N_AUX     = 3,
  parameter int    WORK_BASE = 1,
  parameter int    AUX_BASE  = 9,
  parameter int    CLK_ADDR  = 13,
  parameter int    FIFO_ADDR = 14,
  parameter word_t CLK_RESET = word_t'(190)
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  cmd_t                      cmd,
  input  logic                      cap_en,
  input  logic                      fifo_empty,
  input  word_t                     fifo_data,
  output logic [N_WORK*WORD_W-1:0]  work_flat,
  output logic [N_AUX*WORD_W-1:0]   aux_flat,
  output word_t                     clk_word,
  output word_t                     rd_value,
  output logic                      fifo_pop
);
  word_t work_w [N_WORK];
  word_t aux_w  [N_AUX];

  logic  pend_vld, pend_vld_d;
  addr_t pend_addr, pend_addr_d;
  logic  clk_hit;

  generate
    for (genvar i = 0; i < N_WORK; i++) begin : g_work
      word_t q;
      logic  hit;
      assign hit = cmd.wr && (cmd.addr == addr_t'(WORK_BASE + i));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= cmd.data;
      end
      assign work_w[i] = q;
      assign work_flat[i*WORD_W +: WORD_W] = q;
    end
    for (genvar j = 0; j < N_AUX; j++) begin : g_aux
      word_t q;
      logic  hit;
      assign hit = cmd.wr && (cmd.addr == addr_t'(AUX_BASE + j));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   q <= '0;
        else if (hit) q <= cmd.data;
      end
      assign aux_w[j] = q;
      assign aux_flat[j*WORD_W +: WORD_W] = q;
    end
  endgenerate

  assign clk_hit = cmd.wr && (cmd.addr == addr_t'(CLK_ADDR));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       clk_word <= CLK_RESET;
    else if (clk_hit) clk_word <= cmd.data;
  end

  // pending read request: set at update, consumed by the next capture
  always_comb begin
    pend_vld_d  = pend_vld;
    pend_addr_d = pend_addr;
    if (cap_en) begin
      pend_vld_d = 1'b0;
    end else if (cmd.rd) begin
      pend_vld_d  = 1'b1;
      pend_addr_d = cmd.addr;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_vld  <= 1'b0;
      pend_addr <= '0;
    end else begin
      pend_vld  <= pend_vld_d;
      pend_addr <= pend_addr_d;
    end
  end

  always_comb begin
    rd_value = '0;
    if (pend_addr == addr_t'(CLK_ADDR)) rd_value = clk_word;
    if (pend_addr == addr_t'(FIFO_ADDR)) rd_value = fifo_empty ? '1 : fifo_data;
    for (int i = 0; i < N_WORK; i++)
      if (pend_addr == addr_t'(WORK_BASE + i)) rd_value = work_w[i];
    for (int j = 0; j < N_AUX; j++)
      if (pend_addr == addr_t'(AUX_BASE + j)) rd_value = aux_w[j];
    if (!pend_vld) rd_value = '0;
  end

  assign fifo_pop = cap_en && pend_vld && (pend_addr == addr_t'(FIFO_ADDR)) && !fifo_empty;
endmodule

// File: rtl/jtag_cmd_regbank.sv
module jtag_cmd_regbank
  import jcr_pkg::*;
#(
  parameter int    N_WORK    = 8,
  parameter int    N_AUX     = 3,
  parameter int    WORK_BASE = 1,
  parameter int    AUX_BASE  = 9,
  parameter int    CLK_ADDR  = 13,
  parameter int    FIFO_ADDR = 14,
  parameter word_t CLK_RESET = word_t'(190)
) (
  input  logic                     tck,
  input  logic                     trst_n,
  input  logic                     sel,
  input  logic                     capture,
  input  logic                     shift,
  input  logic                     update,
  input  logic                     tdi,
  output logic                     tdo,
  input  logic                     fifo_empty,
  input  logic [WORD_W-1:0]        fifo_data,
  output logic                     fifo_pop,
  output logic [N_WORK*WORD_W-1:0] work_words,
  output logic [N_AUX*WORD_W-1:0]  aux_words,
  output logic [WORD_W-1:0]        clk_setting
);
  logic   rst_n;
  logic   cap_en, shf_en, upd_en;
  frame_t sr;
  cnt_t   cnt;
  cmd_t   cmd;
  word_t  rd_value;

  // strobe priority capture > shift > update, all gated by select
  assign cap_en = sel && capture;
  assign shf_en = sel && shift && !capture;
  assign upd_en = sel && update && !capture && !shift;

  jcr_rst_sync u_rst (
    .clk    (tck),
    .arst_n (trst_n),
    .rst_n  (rst_n)
  );

  jcr_shift_path u_shift (
    .clk      (tck),
    .rst_n    (rst_n),
    .cap_en   (cap_en),
    .shf_en   (shf_en),
    .load_val (rd_value),
    .tdi      (tdi),
    .sr       (sr),
    .cnt      (cnt),
    .tdo      (tdo)
  );

  jcr_frame_decode u_dec (
    .upd_en (upd_en),
    .sr     (sr),
    .cnt    (cnt),
    .cmd    (cmd)
  );

  jcr_reg_bank #(
    .N_WORK    (N_WORK),
    .N_AUX     (N_AUX),
    .WORK_BASE (WORK_BASE),
    .AUX_BASE  (AUX_BASE),
    .CLK_ADDR  (CLK_ADDR),
    .FIFO_ADDR (FIFO_ADDR),
    .CLK_RESET (CLK_RESET)
  ) u_bank (
    .clk        (tck),
    .rst_n      (rst_n),
    .cmd        (cmd),
    .cap_en     (cap_en),
    .fifo_empty (fifo_empty),
    .fifo_data  (fifo_data),
    .work_flat  (work_words),
    .aux_flat   (aux_words),
    .clk_word   (clk_setting),
    .rd_value   (rd_value),
    .fifo_pop   (fifo_pop)
  );
endmodule

// File: rtl/jtag_cmd_regbank_checker.sv
module jtag_cmd_regbank_checker #(
  parameter int N_WORK = 8,
  parameter int N_AUX  = 3
) (
  input logic                 tck,
  input logic                 trst_n,
  input logic                 sel,
  input logic                 capture,
  input logic                 shift,
  input logic                 update,
  input logic                 tdo,
  input logic                 fifo_empty,
  input logic                 fifo_pop,
  input logic [N_WORK*32-1:0] work_words,
  input logic [N_AUX*32-1:0]  aux_words,
  input logic [31:0]          clk_setting
);
  // R6: pop only in a selected capture cycle with data present
  assert_pop_needs_entry_R6: assert property (@(posedge tck) disable iff (!trst_n)
    fifo_pop |-> (!fifo_empty && sel && capture));

  // R6: pop lasts one cycle
  assert_pop_single_R6: assert property (@(posedge tck) disable iff (!trst_n)
    fifo_pop |=> !fifo_pop);

  // R1: registers move only after a selected update
  assert_hold_without_update_R1: assert property (@(posedge tck) disable iff (!trst_n)
    !(sel && update) |=> ($stable(work_words) && $stable(aux_words) && $stable(clk_setting)));

  // R9: no pop while deselected
  assert_deselect_quiet_R9: assert property (@(posedge tck) disable iff (!trst_n)
    !sel |-> !fifo_pop);

  // R3: TDO moves only on a selected capture or shift
  assert_tdo_hold_R3: assert property (@(posedge tck) disable iff (!trst_n)
    !(sel && (capture || shift)) |=> $stable(tdo));
endmodule

bind jtag_cmd_regbank jtag_cmd_regbank_checker #(
  .N_WORK (N_WORK),
  .N_AUX  (N_AUX)
) u_checker (
  .tck         (tck),
  .trst_n      (trst_n),
  .sel         (sel),
  .capture     (capture),
  .shift       (shift),
  .update      (update),
  .tdo         (tdo),
  .fifo_empty  (fifo_empty),
  .fifo_pop    (fifo_pop),
  .work_words  (work_words),
  .aux_words   (aux_words),
  .clk_setting (clk_setting)
);

// File: tb/jtag_cmd_regbank_test.sv
`timescale 1ns/1ps
module jtag_cmd_regbank_test;
  logic         tck = 1'b0;
  logic         trst_n = 1'b0;
  logic         sel = 1'b0, capture = 1'b0, shift = 1'b0, update = 1'b0, tdi = 1'b0;
  logic         tdo;
  logic         fifo_empty = 1'b1;
  logic [31:0]  fifo_data = 32'h0;
  logic         fifo_pop;
  logic [255:0] work_words;
  logic [95:0]  aux_words;
  logic [31:0]  clk_setting;

  int checks = 0;
  int errors = 0;
  int pops_seen = 0;
  bit running = 1'b0;

  always #10 tck = ~tck;

  jtag_cmd_regbank uut (
    .tck(tck), .trst_n(trst_n), .sel(sel), .capture(capture), .shift(shift),
    .update(update), .tdi(tdi), .tdo(tdo), .fifo_empty(fifo_empty),
    .fifo_data(fifo_data), .fifo_pop(fifo_pop), .work_words(work_words),
    .aux_words(aux_words), .clk_setting(clk_setting)
  );

  // ---------------- reference model ----------------
  logic [31:0] m_work [8];
  logic [31:0] m_aux  [3];
  logic [31:0] m_clk;
  bit          m_pend;
  int          m_pa;
  int          m_cnt;
  bit          m_in  [38];
  bit          m_out [$];
  logic [31:0] fifo_q [$];

  function automatic logic [31:0] m_read(int a);
    if (a >= 1 && a <= 8)  return m_work[a-1];
    if (a >= 9 && a <= 11) return m_aux[a-9];
    if (a == 13)           return m_clk;
    if (a == 14)           return (fifo_q.size() > 0) ? fifo_q[0] : 32'hFFFF_FFFF;
    return 32'h0;
  endfunction

  always @(posedge tck or negedge trst_n) begin
    if (!trst_n) begin
      foreach (m_work[i]) m_work[i] = '0;
      foreach (m_aux[i])  m_aux[i]  = '0;
      m_clk = 32'd190; m_pend = 0; m_pa = 0; m_cnt = 0;
      m_out.delete();
      for (int k = 0; k < 38; k++) m_out.push_back(1'b0);
    end else if (sel && capture) begin
      logic [31:0] v;
      v = m_pend ? m_read(m_pa) : 32'h0;
      if (m_pend && m_pa == 14 && fifo_q.size() > 0) void'(fifo_q.pop_front());
      m_out.delete();
      for (int k = 0; k < 38; k++) m_out.push_back(k < 32 ? v[k] : 1'b0);
      m_cnt = 0; m_pend = 0;
    end else if (sel && shift) begin
      void'(m_out.pop_front());
      m_out.push_back(tdi);
      if (m_cnt < 38) m_in[m_cnt] = tdi;
      if (m_cnt < 39) m_cnt++;
    end else if (sel && update) begin
      int ones; int a; logic [31:0] d;
      ones = 0;
      if (m_cnt == 38) begin
        for (int k = 0; k < 38; k++) ones += m_in[k];
        a = 0; d = '0;
        for (int k = 0; k < 4; k++)  a += m_in[32+k] << k;
        for (int k = 0; k < 32; k++) d[k] = m_in[k];
        if ((ones % 2) == 1 && m_in[36]) begin
          if (a >= 1 && a <= 8)  m_work[a-1] = d;
          if (a >= 9 && a <= 11) m_aux[a-9] = d;
          if (a == 13)           m_clk = d;
        end
      end else if (m_cnt == 6) begin
        for (int k = 0; k < 6; k++) ones += m_in[k];
        a = 0;
        for (int k = 0; k < 4; k++) a += m_in[k] << k;
        if ((ones % 2) == 1 && !m_in[4]) begin m_pend = 1; m_pa = a; end
      end
    end
  end

  // FIFO head driven a little after each rising edge
  always @(posedge tck) begin
    #1;
    fifo_empty = (fifo_q.size() == 0);
    fifo_data  = (fifo_q.size() > 0) ? fifo_q[0] : 32'h0;
  end

  always @(posedge tck) if (trst_n && fifo_pop) pops_seen++;

  // ---------------- every-cycle comparison ----------------
  always @(negedge tck) begin
    #2;
    if (running) begin
      logic [255:0] ew; logic [95:0] ea; logic ep;
      for (int i = 0; i < 8; i++) ew[i*32 +: 32] = m_work[i];
      for (int i = 0; i < 3; i++) ea[i*32 +: 32] = m_aux[i];
      ep = sel && capture && m_pend && m_pa == 14 && fifo_q.size() > 0;
      checks += 5;
      if (tdo !== m_out[0]) begin errors++; $display("FAIL R3 tdo act=%b exp=%b", tdo, m_out[0]); end
      if (fifo_pop !== ep) begin errors++; $display("FAIL R6 fifo_pop act=%b exp=%b", fifo_pop, ep); end
      if (work_words !== ew) begin errors++; $display("FAIL R1 work_words act=%h exp=%h", work_words, ew); end
      if (aux_words !== ea) begin errors++; $display("FAIL R4 aux_words act=%h exp=%h", aux_words, ea); end
      if (clk_setting !== m_clk) begin errors++; $display("FAIL R8 clk_setting act=%h exp=%h", clk_setting, m_clk); end
    end
  end

  // ---------------- helpers ----------------
  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [37:0] wr_frame(int a, logic [31:0] d, bit flag, bit badpar);
    logic [37:0] f;
    f = '0; f[31:0] = d; f[35:32] = a[3:0]; f[36] = flag;
    f[37] = ~(^f[36:0]) ^ badpar;
    return f;
  endfunction

  function automatic logic [37:0] rd_frame(int a, bit flag, bit badpar);
    logic [37:0] f;
    f = '0; f[3:0] = a[3:0]; f[4] = flag;
    f[5] = ~(^f[4:0]) ^ badpar;
    return f;
  endfunction

  task automatic scan(logic [37:0] bits, int n, logic s, output logic [31:0] got);
    got = '0;
    @(negedge tck); sel = s; capture = 1; shift = 0; update = 0;
    for (int k = 0; k < n; k++) begin
      @(negedge tck); capture = 0;
      if (k < 32) got[k] = tdo;
      shift = 1; tdi = bits[k];
    end
    @(negedge tck); capture = 0; shift = 0; update = 1;
    @(negedge tck); update = 0; sel = 0; tdi = 0;
    @(negedge tck);
  endtask

  task automatic write_reg(int a, logic [31:0] d);
    logic [31:0] dummy;
    scan(wr_frame(a, d, 1, 0), 38, 1, dummy);
  endtask

  task automatic read_reg(int a, output logic [31:0] v);
    logic [31:0] dummy;
    scan(rd_frame(a, 0, 0), 6, 1, dummy);
    scan('0, 32, 1, v);
  endtask

  // watchdog
  initial begin
    repeat (100000) @(posedge tck);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, dummy;
    logic [255:0] ws; logic [95:0] as; logic [31:0] cs;
    int p0;
    repeat (5) @(negedge tck);
    trst_n = 1;
    repeat (5) @(negedge tck);
    running = 1;

    // R8: reset state
    chk("R8 clk_setting after reset", clk_setting, 32'd190);
    chk("R8 work word 0 after reset", work_words[31:0], 32'h0);
    chk("R8 tdo after reset", {31'h0, tdo}, 32'h0);

    // R1 / R4: work words
    for (int i = 1; i <= 8; i++) write_reg(i, 32'h1357_0000 + i * 32'h0001_0203);
    for (int i = 1; i <= 8; i++) chk("R1 work word", work_words[(i-1)*32 +: 32], 32'h1357_0000 + i * 32'h0001_0203);
    for (int i = 9; i <= 11; i++) write_reg(i, 32'hC0DE_0000 | i);
    for (int i = 9; i <= 11; i++) chk("R4 data word", aux_words[(i-9)*32 +: 32], 32'hC0DE_0000 | i);
    write_reg(13, 32'd200);
    chk("R4 clock word", clk_setting, 32'd200);

    // R2: bad parity write
    ws = work_words; as = aux_words; cs = clk_setting;
    scan(wr_frame(2, 32'hFFFF_0000, 1, 1), 38, 1, dummy);
    chk("R2 bad parity write ignored", work_words[63:32], ws[63:32]);

    // R4: unmapped write addresses
    write_reg(0, 32'hDEAD_BEEF); write_reg(12, 32'hDEAD_BEEF);
    write_reg(14, 32'hDEAD_BEEF); write_reg(15, 32'hDEAD_BEEF);
    chk("R4 unmapped writes work", (work_words == ws) ? 32'h1 : 32'h0, 32'h1);
    chk("R4 unmapped writes aux", (aux_words == as) ? 32'h1 : 32'h0, 32'h1);
    chk("R4 unmapped writes clock", clk_setting, cs);

    // R7: wrong lengths and wrong flags
    scan(wr_frame(3, 32'h0BAD_0BAD, 1, 0), 37, 1, dummy);
    chk("R7 37-bit frame ignored", work_words[95:64], ws[95:64]);
    scan(wr_frame(3, 32'h0BAD_0BAD, 1, 0), 39, 1, dummy);
    chk("R7 39-bit frame ignored", work_words[95:64], ws[95:64]);
    scan(wr_frame(3, 32'h0BAD_0BAD, 0, 0), 38, 1, dummy);
    chk("R7 write flag 0 ignored", work_words[95:64], ws[95:64]);

    // R9: deselected
    scan(wr_frame(4, 32'h5555_AAAA, 1, 0), 38, 0, dummy);
    chk("R9 deselected write ignored", work_words[127:96], ws[127:96]);

    // R3 / R4: reads
    read_reg(5, v);  chk("R3 read work word 4", v, 32'h1357_0000 + 5 * 32'h0001_0203);
    scan('0, 32, 1, v); chk("R10 second scan reads zero", v, 32'h0);
    read_reg(13, v); chk("R3 read clock word", v, 32'd200);
    read_reg(10, v); chk("R4 read data word 1", v, 32'hC0DE_000A);
    read_reg(15, v); chk("R4 read unmapped", v, 32'h0);

    // R5 / R6: FIFO
    p0 = pops_seen;
    read_reg(14, v); chk("R5 empty fifo read", v, 32'hFFFF_FFFF);
    chk("R6 no pop when empty", pops_seen - p0, 0);
    fifo_q.push_back(32'h1111_2222); fifo_q.push_back(32'h3333_4444);
    repeat (2) @(negedge tck);
    p0 = pops_seen;
    read_reg(14, v); chk("R5 fifo entry 0", v, 32'h1111_2222);
    chk("R6 one pop", pops_seen - p0, 1);
    read_reg(14, v); chk("R5 fifo entry 1", v, 32'h3333_4444);
    chk("R6 second pop", pops_seen - p0, 2);
    read_reg(14, v); chk("R5 drained fifo", v, 32'hFFFF_FFFF);
    chk("R6 no pop after drain", pops_seen - p0, 2);

    // R2 / R7: bad read requests
    scan(rd_frame(5, 0, 1), 6, 1, dummy);
    scan('0, 32, 1, v); chk("R2 bad parity read ignored", v, 32'h0);
    scan(rd_frame(5, 1, 0), 6, 1, dummy);
    scan('0, 32, 1, v); chk("R7 read with write flag ignored", v, 32'h0);

    repeat (3) @(negedge tck);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule